// File: doc/BRIEF.md
# Paged Byte-Memory DMA Engine

This block moves words between on-chip memory and an external memory that is only eight bits wide. A 24-bit program word is built from three consecutive byte accesses. A 16-bit data word is built from two. A single byte can also be placed in the upper or the lower half of a data word. The reverse direction splits an internal word into the same byte sequence. Whatever the width, each internal word costs exactly one cycle on the internal memory port. The byte accesses run on an external bus that the engine requests and that an outside agent grants.

Software sets up the transfer first: a format code, a direction, the internal start address, an external page and offset, and a byte wait count. Writing a non-zero word count then starts the engine. The count register falls by one as each word completes, so it can be polled. When it reaches zero, the engine emits a one-cycle interrupt pulse.

The external byte address is 22 bits: the page forms the upper eight bits and the offset forms the lower fourteen. The address is one counter, so a carry out of the offset advances the page. The address counters keep advancing across transfers until software reprograms them.

Top module: `bytemem_dma`

## Requirements
- R1: After reset the engine is idle, `busy`, `irq`, `ext_req` and `im_req` are low and `cnt_q` is zero; while idle neither bus is requested.
- R2: The external address is {page, offset} (page in bits 21:14). It rises by one after every byte and carries from the offset into the page, wrapping from 0x3FFFFF to 0.
- R3: Each byte access keeps `ext_req`, `ext_addr` and `ext_wdata` steady until it has seen `cfg_wait`+1 cycles with `ext_gnt` high. Cycles without grant do not count. Read data is taken on the last counted cycle.
- R4: Format 0 (`cfg_fmt`=00) takes three bytes per word, the first byte going to bits 23:16, and writes a 24-bit word with `im_pm`=1.
- R5: Format 1 takes two bytes per word, the first byte going to bits 15:8, and writes a data word (`im_pm`=0) with bits 23:16 zero.
- R6: Format 2 puts its single byte in bits 15:8 and format 3 puts it in bits 7:0. All other bits are zero and `im_pm`=0.
- R7: With `cfg_dir`=1 the engine reads one internal word (`im_we`=0) and then writes its bytes externally (`ext_we`=1), most significant first: bits 23:16, 15:8 and 7:0 for format 0; 15:8 and 7:0 for format 1; 15:8 for format 2; 7:0 for format 3. With `cfg_dir`=0 data moves from external to internal memory.
- R8: Each word uses exactly one internal-port cycle (`im_req` high for a single cycle), and the internal address rises by one per word.
- R9: A write of a non-zero count while idle starts a transfer. `cnt_q` shows the remaining words and drops by one in the cycle after each word's final access.
- R10: In the cycle after the last word's final access, `irq` is high for exactly one cycle and `busy` is already low.
- R11: Count writes and configuration writes made while busy are ignored. A count write of zero starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load configuration fields (idle only) |
| cfg_fmt | input | 2 | Packing format code |
| cfg_dir | input | 1 | 0: external to internal, 1: internal to external |
| cfg_wait | input | 3 | Granted cycles per byte minus one |
| cfg_iaddr | input | 14 | Internal start address |
| cfg_page | input | 8 | External start page |
| cfg_offset | input | 14 | External start offset within page |
| cnt_we | input | 1 | Write word count / start |
| cnt_wdata | input | 14 | Word count value |
| cnt_q | output | 14 | Words remaining |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| im_req | output | 1 | Internal memory access this cycle |
| im_we | output | 1 | Internal access is a write |
| im_pm | output | 1 | Internal access targets program memory |
| im_addr | output | 14 | Internal word address |
| im_wdata | output | 24 | Internal write data |
| im_rdata | input | 24 | Internal read data, valid in the same cycle |
| ext_req | output | 1 | External byte bus request / access active |
| ext_gnt | input | 1 | External bus granted this cycle |
| ext_we | output | 1 | External access is a write |
| ext_addr | output | 22 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |

## Verification
The properties assume that `im_rdata` is valid combinationally in the cycle of `im_req`. They also assume that `ext_gnt` may drop at any cycle without the engine having to release its request. The checks assume that software never writes a configuration and a count in the same cycle. The stimulus keeps to these assumptions: combinational memory models drive both read paths, grant follows either a constant or a pseudo-random pattern, and configuration and count writes always come in separate cycles.

// File: rtl/bdma_pkg.sv
// Shared types for the byte-memory DMA engine.
// Assumes format codes are fixed by software convention (see brief).
package bdma_pkg;

    typedef enum logic [1:0] {
        FMT_PM24 = 2'b00,
        FMT_DM16 = 2'b01,
        FMT_DMHI = 2'b10,
        FMT_DMLO = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_BYTE  = 2'b10,
        ST_STORE = 2'b11
    } st_e;

    // Index of the last byte of a word for a given format.
    function automatic logic [1:0] last_byte_idx(fmt_e f);
        case (f)
            FMT_PM24: return 2'd2;
            FMT_DM16: return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/bdma_pack.sv
// Format converter: turns the byte accumulator into an internal word and
// an internal word into an accumulator aligned for most-significant-first
// sending. Purely combinational; assumes the accumulator holds the bytes
// in arrival order in its low bits.
module bdma_pack
    import bdma_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  fmt_e                 fmt,
    input  logic [3*BYTE_W-1:0]  acc,
    input  logic [3*BYTE_W-1:0]  rdata,
    output logic [3*BYTE_W-1:0]  store_word,
    output logic [3*BYTE_W-1:0]  load_word
);
    localparam int B = BYTE_W;

    // Build the word written to internal memory.
    always_comb begin
        case (fmt)
            FMT_PM24: store_word = acc;
            FMT_DM16: store_word = {{B{1'b0}}, acc[2*B-1:0]};
            FMT_DMHI: store_word = {{B{1'b0}}, acc[B-1:0], {B{1'b0}}};
            default:  store_word = {{(2*B){1'b0}}, acc[B-1:0]};
        endcase
    end

    // Align a word read from internal memory so its first byte sits on top.
    always_comb begin
        case (fmt)
            FMT_PM24: load_word = rdata;
            FMT_DM16: load_word = {rdata[2*B-1:0], {B{1'b0}}};
            FMT_DMHI: load_word = {rdata[2*B-1:B], {(2*B){1'b0}}};
            default:  load_word = {rdata[B-1:0], {(2*B){1'b0}}};
        endcase
    end

endmodule

// File: rtl/bdma_addr.sv
// Address counters: one combined page/offset byte address and one internal
// word address. Both load on an accepted configuration write and step on
// the strobes from the controller; the page carries naturally.
module bdma_addr #(
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 14,
    parameter int IADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ld,
    input  logic [PAGE_W-1:0]       ld_page,
    input  logic [OFF_W-1:0]        ld_off,
    input  logic [IADDR_W-1:0]      ld_iaddr,
    input  logic                    e_inc,
    input  logic                    i_inc,
    output logic [PAGE_W+OFF_W-1:0] eaddr,
    output logic [IADDR_W-1:0]      iaddr
);
    localparam int EA_W = PAGE_W + OFF_W;

    // External byte address: load or step by one byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     eaddr <= '0;
        else if (ld)    eaddr <= {ld_page, ld_off};
        else if (e_inc) eaddr <= eaddr + EA_W'(1);
    end

    // Internal word address: load or step by one word.
    always_ff @(posedge clk) begin
        if (!rst_n)     iaddr <= '0;
        else if (ld)    iaddr <= ld_iaddr;
        else if (i_inc) iaddr <= iaddr + IADDR_W'(1);
    end

endmodule

// File: rtl/bdma_ctrl.sv
// Transfer sequencer: holds format/direction/wait settings and the word
// count, steps through internal load, byte accesses and internal store,
// and pulses the completion interrupt. Assumes the internal port answers
// in the same cycle and that ext_gnt may drop at any time.
module bdma_ctrl
    import bdma_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 14,
    parameter int WAIT_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_ld,
    input  logic [1:0]          cfg_fmt,
    input  logic                cfg_dir,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                cnt_we,
    input  logic [CNT_W-1:0]    cnt_wdata,
    input  logic                ext_gnt,
    input  logic [BYTE_W-1:0]   ext_rdata,
    input  logic [3*BYTE_W-1:0] load_word,
    output fmt_e                fmt_q,
    output logic [3*BYTE_W-1:0] acc_q,
    output logic [CNT_W-1:0]    cnt_q,
    output logic                busy,
    output logic                irq,
    output logic                ext_req,
    output logic                ext_we,
    output logic [BYTE_W-1:0]   ext_wdata,
    output logic                im_req,
    output logic                im_we,
    output logic                e_inc,
    output logic                i_inc
);
    localparam int WORD_W = 3 * BYTE_W;

    st_e               st;
    logic              dir_q;
    logic [WAIT_W-1:0] wait_q;
    logic [1:0]        bidx;
    logic [WAIT_W-1:0] wcnt;
    logic [WORD_W-1:0] acc;
    logic [CNT_W-1:0]  cnt;
    logic              irq_q;

    logic idle, start, byte_done, word_end, last_word;
    logic [1:0] nb_last;

    // Decode of the current step.
    always_comb begin
        idle      = (st == ST_IDLE);
        start     = idle && cnt_we && (cnt_wdata != '0);
        byte_done = (st == ST_BYTE) && ext_gnt && (wcnt == wait_q);
        word_end  = (st == ST_STORE) || (byte_done && dir_q && (bidx == 2'd0));
        last_word = word_end && (cnt == CNT_W'(1));
        nb_last   = last_byte_idx(fmt_q);
    end

    // Configuration holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_PM24;
            dir_q  <= 1'b0;
            wait_q <= '0;
        end else if (cfg_ld) begin
            fmt_q  <= fmt_e'(cfg_fmt);
            dir_q  <= cfg_dir;
            wait_q <= cfg_wait;
        end
    end

    // Word count: loaded on start, decremented at each word end.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (start)    cnt <= cnt_wdata;
        else if (word_end) cnt <= cnt - CNT_W'(1);
    end

    // Completion pulse, one cycle after the final access.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= last_word;
    end

    // Main sequencer with byte index, wait counter and accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            bidx <= '0;
            wcnt <= '0;
            acc  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= dir_q ? ST_LOAD : ST_BYTE;
                        bidx <= nb_last;
                        wcnt <= '0;
                    end
                end
                ST_LOAD: begin
                    acc <= load_word;
                    st  <= ST_BYTE;
                end
                ST_BYTE: begin
                    if (ext_gnt) begin
                        if (wcnt == wait_q) begin
                            wcnt <= '0;
                            acc  <= dir_q ? (acc << BYTE_W)
                                          : {acc[WORD_W-BYTE_W-1:0], ext_rdata};
                            if (bidx == 2'd0) begin
                                bidx <= nb_last;
                                if (!dir_q)         st <= ST_STORE;
                                else if (last_word) st <= ST_IDLE;
                                else                st <= ST_LOAD;
                            end else begin
                                bidx <= bidx - 2'd1;
                            end
                        end else begin
                            wcnt <= wcnt + WAIT_W'(1);
                        end
                    end
                end
                default: begin
                    bidx <= nb_last;
                    st   <= last_word ? ST_IDLE : ST_BYTE;
                end
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy      = !idle;
        irq       = irq_q;
        cnt_q     = cnt;
        acc_q     = acc;
        ext_req   = (st == ST_BYTE);
        ext_we    = dir_q;
        ext_wdata = acc[WORD_W-1 -: BYTE_W];
        im_req    = (st == ST_LOAD) || (st == ST_STORE);
        im_we     = (st == ST_STORE);
        e_inc     = byte_done;
        i_inc     = im_req;
    end

endmodule

// File: rtl/bytemem_dma.sv
// Top of the byte-memory DMA engine: wires the sequencer, the format
// converter and the address counters. Configuration writes are accepted
// only while idle; the internal port is assumed single-cycle.
module bytemem_dma
    import bdma_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int CNT_W   = 14,
    parameter int WAIT_W  = 3,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 14,
    parameter int IADDR_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_fmt,
    input  logic                    cfg_dir,
    input  logic [WAIT_W-1:0]       cfg_wait,
    input  logic [IADDR_W-1:0]      cfg_iaddr,
    input  logic [PAGE_W-1:0]       cfg_page,
    input  logic [OFF_W-1:0]        cfg_offset,
    input  logic                    cnt_we,
    input  logic [CNT_W-1:0]        cnt_wdata,
    output logic [CNT_W-1:0]        cnt_q,
    output logic                    busy,
    output logic                    irq,
    output logic                    im_req,
    output logic                    im_we,
    output logic                    im_pm,
    output logic [IADDR_W-1:0]      im_addr,
    output logic [3*BYTE_W-1:0]     im_wdata,
    input  logic [3*BYTE_W-1:0]     im_rdata,
    output logic                    ext_req,
    input  logic                    ext_gnt,
    output logic                    ext_we,
    output logic [PAGE_W+OFF_W-1:0] ext_addr,
    output logic [BYTE_W-1:0]       ext_wdata,
    input  logic [BYTE_W-1:0]       ext_rdata
);
    localparam int WORD_W = 3 * BYTE_W;

    fmt_e              fmt_q;
    logic [WORD_W-1:0] acc_q, store_word, load_word;
    logic              cfg_ld, e_inc, i_inc;

    // Configuration is taken only while no transfer runs.
    always_comb cfg_ld = cfg_we && !busy;

    bdma_ctrl #(
        .BYTE_W (BYTE_W),
        .CNT_W  (CNT_W),
        .WAIT_W (WAIT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_ld    (cfg_ld),
        .cfg_fmt   (cfg_fmt),
        .cfg_dir   (cfg_dir),
        .cfg_wait  (cfg_wait),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .ext_gnt   (ext_gnt),
        .ext_rdata (ext_rdata),
        .load_word (load_word),
        .fmt_q     (fmt_q),
        .acc_q     (acc_q),
        .cnt_q     (cnt_q),
        .busy      (busy),
        .irq       (irq),
        .ext_req   (ext_req),
        .ext_we    (ext_we),
        .ext_wdata (ext_wdata),
        .im_req    (im_req),
        .im_we     (im_we),
        .e_inc     (e_inc),
        .i_inc     (i_inc)
    );

    bdma_pack #(
        .BYTE_W (BYTE_W)
    ) u_pack (
        .fmt        (fmt_q),
        .acc        (acc_q),
        .rdata      (im_rdata),
        .store_word (store_word),
        .load_word  (load_word)
    );

    bdma_addr #(
        .PAGE_W  (PAGE_W),
        .OFF_W   (OFF_W),
        .IADDR_W (IADDR_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (cfg_ld),
        .ld_page  (cfg_page),
        .ld_off   (cfg_offset),
        .ld_iaddr (cfg_iaddr),
        .e_inc    (e_inc),
        .i_inc    (i_inc),
        .eaddr    (ext_addr),
        .iaddr    (im_addr)
    );

    // Internal port data and space select.
    always_comb begin
        im_wdata = store_word;
        im_pm    = (fmt_q == FMT_PM24);
    end

endmodule

// File: rtl/bytemem_dma_chk.sv
// Property checker for the byte-memory DMA engine, bound to the top.
// Assumes ext_gnt may drop at any cycle and the internal port is single-cycle.
module bytemem_dma_chk #(
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 14,
    parameter int EA_W   = 22
) (
    input logic                clk,
    input logic                rst_n,
    input logic                busy,
    input logic                irq,
    input logic                cnt_we,
    input logic [CNT_W-1:0]    cnt_q,
    input logic                im_req,
    input logic                im_we,
    input logic                im_pm,
    input logic [3*BYTE_W-1:0] im_wdata,
    input logic                ext_req,
    input logic                ext_gnt,
    input logic [EA_W-1:0]     ext_addr,
    input logic [BYTE_W-1:0]   ext_wdata
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ext_req && !im_req));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R10
    irq_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R3
    hold_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_gnt) |=> (ext_req && $stable(ext_addr) && $stable(ext_wdata)));

    // R8
    one_int_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        im_req |=> !im_req);

    // R11
    busy_cnt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_we) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R6
    dm_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (im_req && im_we && !im_pm) |-> (im_wdata[3*BYTE_W-1 -: BYTE_W] == '0));

endmodule

bind bytemem_dma bytemem_dma_chk #(
    .BYTE_W (BYTE_W),
    .CNT_W  (CNT_W),
    .EA_W   (PAGE_W + OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .irq       (irq),
    .cnt_we    (cnt_we),
    .cnt_q     (cnt_q),
    .im_req    (im_req),
    .im_we     (im_we),
    .im_pm     (im_pm),
    .im_wdata  (im_wdata),
    .ext_req   (ext_req),
    .ext_gnt   (ext_gnt),
    .ext_addr  (ext_addr),
    .ext_wdata (ext_wdata)
);

// File: tb/bytemem_dma_bench.sv
// Bench: an event-queue reference model predicts every internal access and
// every granted byte cycle; outputs are compared at each falling edge.
module bytemem_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_fmt = '0;
    logic        cfg_dir = 1'b0;
    logic [2:0]  cfg_wait = '0;
    logic [13:0] cfg_iaddr = '0;
    logic [7:0]  cfg_page = '0;
    logic [13:0] cfg_offset = '0;
    logic        cnt_we = 1'b0;
    logic [13:0] cnt_wdata = '0;
    logic [13:0] cnt_q;
    logic        busy, irq;
    logic        im_req, im_we, im_pm;
    logic [13:0] im_addr;
    logic [23:0] im_wdata, im_rdata;
    logic        ext_req, ext_we;
    logic        ext_gnt = 1'b0;
    logic [21:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;

    always #4 clk = ~clk;

    function automatic logic [7:0] ext_byte(logic [21:0] a);
        return (a[7:0] * 8'd7) ^ a[21:14] ^ {a[13:8], 2'b01} ^ 8'h3C;
    endfunction

    function automatic logic [23:0] int_word(logic [13:0] a);
        return {a[7:0] ^ 8'hA5, a[13:6] + 8'h11, a[7:0] ^ 8'h5E};
    endfunction

    assign ext_rdata = ext_byte(ext_addr);
    assign im_rdata  = int_word(im_addr);

    bytemem_dma u_bytemem_dma (.*);

    typedef struct packed {
        logic        is_int;
        logic        we;
        logic        pm;
        logic        last;
        logic [21:0] addr;
        logic [23:0] data;
    } ev_t;

    ev_t         q[$];
    ev_t         ev;
    int          n_tests = 0;
    int          n_fail = 0;
    int          words_left = 0;
    int          run = 0;
    int          cyc = 0;
    bit          irq_exp = 1'b0;
    bit          gnt_rand = 1'b0;
    bit          done = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string       cur_tag = "R1";

    logic [1:0]  m_fmt = '0;
    logic        m_dir = 1'b0;
    int          m_wait = 0;
    logic [13:0] m_iaddr = '0;
    logic [21:0] m_eaddr = '0;

    task automatic chk(bit ok, string tag, string what, int unsigned act, int unsigned exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Per-cycle comparison against the event queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "R9", "watchdog expired", 0, 1);
                finish_run();
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_gnt = gnt_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
            chk(busy == (q.size() != 0), "R10", "busy", busy, q.size() != 0);
            chk(irq == irq_exp, "R10", "irq", irq, irq_exp);
            irq_exp = 1'b0;
            chk(cnt_q == 14'(words_left), "R9", "count", cnt_q, words_left);
            if (q.size() == 0) begin
                chk(!ext_req && !im_req, "R8", "no access when idle", {ext_req, im_req}, 0);
            end else begin
                ev = q[0];
                if (ev.is_int) begin
                    chk(!ext_req, "R8", "no byte access during word cycle", ext_req, 0);
                    chk(im_req, "R8", "internal access expected", im_req, 1);
                    if (im_req) begin
                        chk(im_addr == ev.addr[13:0], "R8", "internal address", im_addr, ev.addr);
                        chk(im_we == ev.we, "R7", "internal direction", im_we, ev.we);
                        chk(im_pm == ev.pm, cur_tag, "program select", im_pm, ev.pm);
                        if (ev.we)
                            chk(im_wdata == ev.data, cur_tag, "internal word", im_wdata, ev.data);
                        void'(q.pop_front());
                        if (ev.last) words_left--;
                        if (q.size() == 0) irq_exp = 1'b1;
                    end
                end else begin
                    chk(!im_req, "R8", "no internal access during byte", im_req, 0);
                    chk(ext_req, "R3", "byte request expected", ext_req, 1);
                    if (ext_req) begin
                        chk(ext_addr == ev.addr, "R2", "byte address", ext_addr, ev.addr);
                        chk(ext_we == ev.we, "R7", "byte direction", ext_we, ev.we);
                        if (ev.we)
                            chk(ext_wdata == ev.data[7:0], cur_tag, "byte out", ext_wdata, ev.data);
                        if (ext_gnt) begin
                            run++;
                            if (run == m_wait + 1) begin
                                run = 0;
                                void'(q.pop_front());
                                if (ev.last) words_left--;
                                if (q.size() == 0) irq_exp = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic push_ev(bit is_int, bit we, bit pm, bit last, logic [21:0] a, logic [23:0] d);
        ev_t e;
        e.is_int = is_int; e.we = we; e.pm = pm; e.last = last; e.addr = a; e.data = d;
        q.push_back(e);
    endtask

    // Builds the expected access list of one transfer from the requirements.
    task automatic build(int n);
        int nb;
        logic [23:0] acc, w;
        nb = (m_fmt == 2'd0) ? 3 : (m_fmt == 2'd1) ? 2 : 1;
        for (int k = 0; k < n; k++) begin
            if (!m_dir) begin
                acc = '0;
                for (int b = 0; b < nb; b++) begin
                    push_ev(0, 0, 0, 0, m_eaddr, {16'h0, ext_byte(m_eaddr)});
                    acc = (acc << 8) | {16'h0, ext_byte(m_eaddr)};
                    m_eaddr = m_eaddr + 22'd1;
                end
                case (m_fmt)
                    2'd0: w = acc;
                    2'd1: w = {8'h0, acc[15:0]};
                    2'd2: w = {8'h0, acc[7:0], 8'h0};
                    default: w = {16'h0, acc[7:0]};
                endcase
                push_ev(1, 1, m_fmt == 2'd0, 1, {8'h0, m_iaddr}, w);
            end else begin
                w = int_word(m_iaddr);
                push_ev(1, 0, m_fmt == 2'd0, 0, {8'h0, m_iaddr}, w);
                for (int b = 0; b < nb; b++) begin
                    case (m_fmt)
                        2'd0: acc = {16'h0, w[23 - 8*b -: 8]};
                        2'd1: acc = {16'h0, w[15 - 8*b -: 8]};
                        2'd2: acc = {16'h0, w[15:8]};
                        default: acc = {16'h0, w[7:0]};
                    endcase
                    push_ev(0, 1, 0, b == nb - 1, m_eaddr, acc);
                    m_eaddr = m_eaddr + 22'd1;
                end
            end
            m_iaddr = m_iaddr + 14'd1;
        end
    endtask

    task automatic do_cfg(logic [1:0] f, logic d, logic [2:0] wt, logic [13:0] ia,
                          logic [7:0] pg, logic [13:0] off, bit accept);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_fmt = f; cfg_dir = d; cfg_wait = wt;
        cfg_iaddr = ia; cfg_page = pg; cfg_offset = off;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        if (accept) begin
            m_fmt = f; m_dir = d; m_wait = int'(wt); m_iaddr = ia; m_eaddr = {pg, off};
        end
    endtask

    task automatic do_cnt(int n, bit accept);
        @(posedge clk); #1;
        cnt_we = 1'b1; cnt_wdata = 14'(n);
        @(posedge clk); #1;
        cnt_we = 1'b0;
        if (accept) begin
            build(n);
            words_left = n;
            run = 0;
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (q.size() == 0 && !busy) break;
        end
        repeat (3) @(negedge clk);
        chk(q.size() == 0, cur_tag, "transfer finished", q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !irq && cnt_q == 0 && !ext_req && !im_req, "R1", "reset state",
            {busy, irq, ext_req, im_req, 14'(cnt_q)}, 0);

        // R4: 24-bit program words, no wait, constant grant
        cur_tag = "R4";
        do_cfg(2'd0, 1'b0, 3'd0, 14'h0010, 8'h03, 14'h0100, 1);
        do_cnt(3, 1); wait_done();

        // R5 with R3: two bytes per word, wait 2, gapped grant
        cur_tag = "R5"; gnt_rand = 1'b1;
        do_cfg(2'd1, 1'b0, 3'd2, 14'h0200, 8'h10, 14'h0800, 1);
        do_cnt(4, 1); wait_done();

        // R6: byte into high half, then into low half
        cur_tag = "R6";
        do_cfg(2'd2, 1'b0, 3'd0, 14'h0300, 8'h20, 14'h0040, 1);
        do_cnt(2, 1); wait_done();
        do_cfg(2'd3, 1'b0, 3'd1, 14'h0310, 8'h21, 14'h0050, 1);
        do_cnt(2, 1); wait_done();

        // R7: internal to external for every format
        cur_tag = "R7";
        for (int f = 0; f < 4; f++) begin
            do_cfg(2'(f), 1'b1, 3'd1, 14'(16'h1000 + f * 16), 8'h40, 14'(f * 32), 1);
            do_cnt(2, 1); wait_done();
        end

        // R2: page crossing, then wrap of the full 22-bit address
        cur_tag = "R2";
        do_cfg(2'd1, 1'b0, 3'd0, 14'h0400, 8'h05, 14'h3FFE, 1);
        do_cnt(3, 1); wait_done();
        do_cfg(2'd3, 1'b1, 3'd0, 14'h0410, 8'hFF, 14'h3FFF, 1);
        do_cnt(2, 1); wait_done();

        // R11: count and configuration writes while busy are ignored
        cur_tag = "R11";
        do_cfg(2'd1, 1'b0, 3'd3, 14'h0500, 8'h30, 14'h0000, 1);
        do_cnt(5, 1);
        repeat (4) @(negedge clk);
        do_cnt(100, 0);
        do_cfg(2'd0, 1'b1, 3'd0, 14'h3000, 8'h77, 14'h1234, 0);
        wait_done();
        do_cnt(1, 1); wait_done();

        // R11: zero count starts nothing
        do_cnt(0, 0);
        repeat (6) @(negedge clk);
        chk(!busy && !irq && !ext_req, "R11", "zero count idle", {busy, irq, ext_req}, 0);

        // R9: long transfer with count polling
        cur_tag = "R9"; gnt_rand = 1'b0;
        do_cfg(2'd0, 1'b1, 3'd0, 14'h3FFE, 8'h60, 14'h0000, 1);
        do_cnt(20, 1); wait_done();

        finish_run();
    end

endmodule